// File: doc/BRIEF.md
# User-Mode Base/Mask Address Translator

This block sits between a 24-bit, 68000-style CPU bus and main memory. It gives every user-mode program a private region of memory. The region's size is a power of two and its base is aligned to that size. For each user access, the page bits of the CPU address are first limited by a mask and then merged with a base. The resulting physical address goes to memory. If the access reaches beyond the region, a bus error is raised instead. Supervisor accesses are not modified.

Supervisor code sets up the region through a small write-only register window at the top of the address space. The window has four byte-wide fields: the low and high parts of the base, and the low and high parts of the mask. A write stores only the upper data byte. Translation and the range check are combinational on the current bus cycle, so the bus error can take the place of the normal acknowledge. Configuration writes take effect at the clock edge that samples them.

Top module: `ubm_translator`

## Requirements
- R1: After reset, all four configuration fields read as zero. With these values, a user access keeps bits 11:1 and has page bits 23:12 of zero.
- R2: When fc2 is 1 (supervisor), phys_addr equals cpu_addr and bus_err is 0.
- R3: Address bits 11:1 pass from cpu_addr to phys_addr unchanged in every mode.
- R4: For a user access (fc2 = 0), phys_addr[23:12] = (cpu_addr[23:12] AND mask) OR base. Here mask = {2'b00, mask_hi[1:0], mask_lo[7:0]} and base = {1'b0, base_hi[2:0], base_lo[7:0]}.
- R5: While as_n is 0 and fc2 is 0, bus_err is 1 exactly when some bit of cpu_addr[23:12] is 1 where the mask of R4 has a 0. Bits 23 and 22 are never covered by the mask, so a user access to the configuration window always errors.
- R6: bus_err is 0 while as_n is 1, whatever the address and mode.
- R7: A write cycle loads one configuration field. The cycle needs as_n = 0, rw_n = 0, fc2 = 1, uds_n = 0 and a byte address of FE0000h, FE0002h, FE0004h or FE0006h. Address bits 2:1 = 0, 1, 2, 3 select base_lo, base_hi, mask_lo and mask_hi. The field takes cfg_wdata (data bits 15:8): base_hi takes its low 3 bits and mask_hi its low 2 bits. The new value applies from the sampling clock edge onward.
- R8: Write cycles with fc2 = 0 leave the configuration unchanged.
- R9: A cycle leaves the configuration unchanged if it has uds_n = 1, or is a read (rw_n = 1), or targets any window address other than the four in R7 (for example FE0008h).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| as_n | input | 1 | Address strobe, active low |
| uds_n | input | 1 | Upper data strobe, active low |
| rw_n | input | 1 | 1 = read, 0 = write |
| fc2 | input | 1 | Function code bit 2: 1 supervisor, 0 user |
| cpu_addr | input | 23 | CPU address bits 23:1 |
| cfg_wdata | input | 8 | CPU data bits 15:8 for configuration writes |
| phys_addr | output | 23 | Physical address bits 23:1 |
| bus_err | output | 1 | Bus error for an out-of-range user access |

## Verification
phys_addr and bus_err are combinational functions of the present bus inputs and the stored configuration. Each access check therefore drives its inputs on the falling clock edge and samples one nanosecond later, in the same cycle, with no clock edge in between. A configuration write is held across exactly one rising edge. It is released on the following falling edge, and only later accesses are checked against it. The same timing shows that an ignored write has changed nothing: the next access still translates with the old values.

// File: rtl/ubm_pkg.sv
package ubm_pkg;
    localparam int ADDR_W    = 24;
    localparam int PAGE_LSB  = 12;
    localparam int BASE_MSB  = 22;
    localparam int MASK_MSB  = 21;
    localparam int FIELD_W   = 8;
    localparam int PAGE_W    = ADDR_W - PAGE_LSB;
    localparam int BASE_HI_W = BASE_MSB - PAGE_LSB + 1 - FIELD_W;
    localparam int MASK_HI_W = MASK_MSB - PAGE_LSB + 1 - FIELD_W;
    localparam int BASE_PAD  = PAGE_W - (BASE_MSB - PAGE_LSB + 1);
    localparam int MASK_PAD  = PAGE_W - (MASK_MSB - PAGE_LSB + 1);

    typedef enum logic [1:0] {
        SEL_BASE_LO = 2'd0,
        SEL_BASE_HI = 2'd1,
        SEL_MASK_LO = 2'd2,
        SEL_MASK_HI = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic [BASE_HI_W-1:0] base_hi;
        logic [FIELD_W-1:0]   base_lo;
        logic [MASK_HI_W-1:0] mask_hi;
        logic [FIELD_W-1:0]   mask_lo;
    } mmu_cfg_t;
endpackage

// File: rtl/ubm_decode.sv
module ubm_decode
    import ubm_pkg::*;
#(
    parameter logic [7:0] CFG_PAGE = 8'hFE
) (
    input  logic              as_n,
    input  logic              uds_n,
    input  logic              rw_n,
    input  logic              fc2,
    input  logic [ADDR_W-1:1] cpu_addr,
    output logic              wr_en,
    output cfg_sel_e          wr_sel
);
    logic in_page;
    logic in_slots;

    always_comb begin
        in_page  = (cpu_addr[ADDR_W-1:ADDR_W-8] == CFG_PAGE);
        in_slots = (cpu_addr[ADDR_W-9:3] == '0);
        wr_en    = !as_n && !rw_n && fc2 && !uds_n && in_page && in_slots;
        wr_sel   = cfg_sel_e'(cpu_addr[2:1]);
    end
endmodule

// File: rtl/ubm_cfg_regs.sv
module ubm_cfg_regs
    import ubm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  cfg_sel_e           wr_sel,
    input  logic [FIELD_W-1:0] wr_byte,
    output mmu_cfg_t           cfg_q
);
    mmu_cfg_t cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (wr_sel)
                SEL_BASE_LO: cfg_d.base_lo = wr_byte;
                SEL_BASE_HI: cfg_d.base_hi = wr_byte[BASE_HI_W-1:0];
                SEL_MASK_LO: cfg_d.mask_lo = wr_byte;
                SEL_MASK_HI: cfg_d.mask_hi = wr_byte[MASK_HI_W-1:0];
                default:     cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end
endmodule

// File: rtl/ubm_xlate.sv
module ubm_xlate
    import ubm_pkg::*;
(
    input  logic              as_n,
    input  logic              fc2,
    input  logic [ADDR_W-1:1] cpu_addr,
    input  mmu_cfg_t          cfg,
    output logic [ADDR_W-1:1] phys_addr,
    output logic              bus_err
);
    logic [PAGE_W-1:0] page;
    logic [PAGE_W-1:0] mask_page;
    logic [PAGE_W-1:0] base_page;
    logic [PAGE_W-1:0] user_page;
    logic              outside;

    always_comb begin
        page      = cpu_addr[ADDR_W-1:PAGE_LSB];
        mask_page = {{MASK_PAD{1'b0}}, cfg.mask_hi, cfg.mask_lo};
        base_page = {{BASE_PAD{1'b0}}, cfg.base_hi, cfg.base_lo};
        user_page = (page & mask_page) | base_page;
        outside   = |(page & ~mask_page);
        phys_addr = fc2 ? cpu_addr : {user_page, cpu_addr[PAGE_LSB-1:1]};
        bus_err   = !as_n && !fc2 && outside;
    end
endmodule

// File: rtl/ubm_translator.sv
module ubm_translator
    import ubm_pkg::*;
#(
    parameter logic [7:0] CFG_PAGE = 8'hFE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              as_n,
    input  logic              uds_n,
    input  logic              rw_n,
    input  logic              fc2,
    input  logic [ADDR_W-1:1] cpu_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [ADDR_W-1:1] phys_addr,
    output logic              bus_err
);
    logic     wr_en;
    cfg_sel_e wr_sel;
    mmu_cfg_t cfg_q;

    ubm_decode #(.CFG_PAGE(CFG_PAGE)) u_decode (
        .as_n     (as_n),
        .uds_n    (uds_n),
        .rw_n     (rw_n),
        .fc2      (fc2),
        .cpu_addr (cpu_addr),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel)
    );

    ubm_cfg_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_byte (cfg_wdata),
        .cfg_q   (cfg_q)
    );

    ubm_xlate u_xlate (
        .as_n      (as_n),
        .fc2       (fc2),
        .cpu_addr  (cpu_addr),
        .cfg       (cfg_q),
        .phys_addr (phys_addr),
        .bus_err   (bus_err)
    );
endmodule

// File: rtl/ubm_translator_chk.sv
module ubm_translator_chk
    import ubm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              as_n,
    input logic              fc2,
    input logic [ADDR_W-1:1] cpu_addr,
    input logic [ADDR_W-1:1] phys_addr,
    input logic              bus_err,
    input mmu_cfg_t          cfg
);
    logic [PAGE_W-1:0] ck_mask;
    logic [PAGE_W-1:0] ck_base;
    assign ck_mask = {{MASK_PAD{1'b0}}, cfg.mask_hi, cfg.mask_lo};
    assign ck_base = {{BASE_PAD{1'b0}}, cfg.base_hi, cfg.base_lo};

    // R2
    super_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!as_n && fc2) |-> (phys_addr == cpu_addr && !bus_err));

    // R6
    err_needs_user_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (!as_n && !fc2));

    // R3
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phys_addr[PAGE_LSB-1:1] == cpu_addr[PAGE_LSB-1:1]);

    // R4
    in_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!as_n && !fc2 && !bus_err) |->
        ((phys_addr[ADDR_W-1:PAGE_LSB] & ~ck_mask) == (ck_base & ~ck_mask)));

    // R8
    user_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fc2 |=> $stable(cfg));
endmodule

bind ubm_translator ubm_translator_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .as_n      (as_n),
    .fc2       (fc2),
    .cpu_addr  (cpu_addr),
    .phys_addr (phys_addr),
    .bus_err   (bus_err),
    .cfg       (cfg_q)
);

// File: tb/ubm_translator_test.sv
module ubm_translator_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        as_n = 1'b1;
    logic        uds_n = 1'b1;
    logic        rw_n = 1'b1;
    logic        fc2 = 1'b1;
    logic [23:1] cpu_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [23:1] phys_addr;
    logic        bus_err;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [7:0] m_base_lo = 0, m_mask_lo = 0;
    logic [2:0] m_base_hi = 0;
    logic [1:0] m_mask_hi = 0;

    always #5 clk = ~clk;

    ubm_translator uut (
        .clk(clk), .rst_n(rst_n), .as_n(as_n), .uds_n(uds_n), .rw_n(rw_n),
        .fc2(fc2), .cpu_addr(cpu_addr), .cfg_wdata(cfg_wdata),
        .phys_addr(phys_addr), .bus_err(bus_err)
    );

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_idle();
        @(negedge clk);
        as_n = 1'b1; uds_n = 1'b1; rw_n = 1'b1; fc2 = 1'b1;
    endtask

    task automatic cyc_write(input logic [23:0] a, input logic [7:0] d,
                             input logic s, input logic u_n, input logic r_n);
        @(negedge clk);
        cpu_addr = a[23:1]; cfg_wdata = d; fc2 = s; uds_n = u_n; rw_n = r_n; as_n = 1'b0;
        @(posedge clk);
        bus_idle();
    endtask

    task automatic model_write(input logic [23:0] a, input logic [7:0] d);
        cyc_write(a, d, 1'b1, 1'b0, 1'b0);
        case (a[2:1])
            2'd0: m_base_lo = d;
            2'd1: m_base_hi = d[2:0];
            2'd2: m_mask_lo = d;
            default: m_mask_hi = d[1:0];
        endcase
    endtask

    task automatic access(input string req, input logic [23:0] a, input logic s, input logic strobe_n);
        logic [11:0] mask, base, pg;
        logic [23:0] ep;
        logic        ee;
        @(negedge clk);
        cpu_addr = a[23:1]; fc2 = s; as_n = strobe_n; rw_n = 1'b1; uds_n = 1'b0;
        #1;
        mask = {2'b00, m_mask_hi, m_mask_lo};
        base = {1'b0, m_base_hi, m_base_lo};
        pg   = a[23:12];
        if (s) begin
            ep = {a[23:1], 1'b0};
            ee = 1'b0;
        end else begin
            ep = {(pg & mask) | base, a[11:1], 1'b0};
            ee = !strobe_n && ((pg & ~mask) != 0);
        end
        check({req, " addr"}, {phys_addr, 1'b0}, ep);
        check({req, " err"}, {23'd0, bus_err}, {23'd0, ee});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_base_lo = 0; m_base_hi = 0; m_mask_lo = 0; m_mask_hi = 0;
    endtask

    task automatic t_reset_state();
        access("R1", 24'h000ABC, 1'b0, 1'b0);
        check("R1 page zero", {phys_addr, 1'b0}, 24'h000ABC);
        access("R5 reset range", 24'h001000, 1'b0, 1'b0);
        check("R5 err after reset", {23'd0, bus_err}, 24'd1);
    endtask

    task automatic t_supervisor();
        access("R2", 24'h123456, 1'b1, 1'b0);
        access("R2 high", 24'hFFFFFE, 1'b1, 1'b0);
        access("R3 offset", 24'h000FFE, 1'b0, 1'b0);
    endtask

    task automatic t_small_region();
        model_write(24'hFE0000, 8'h40);
        model_write(24'hFE0002, 8'hF5);
        model_write(24'hFE0004, 8'h0F);
        model_write(24'hFE0006, 8'h00);
        access("R7 R4 small", 24'h00ABCE, 1'b0, 1'b0);
        check("R4 explicit", {phys_addr, 1'b0}, 24'h54ABCE);
        access("R5 just above", 24'h010000, 1'b0, 1'b0);
        access("R5 bit22", 24'h400000, 1'b0, 1'b0);
        access("R5 bit23", 24'h800000, 1'b0, 1'b0);
        access("R2 during region", 24'h010000, 1'b1, 1'b0);
    endtask

    task automatic t_large_region();
        model_write(24'hFE0004, 8'hFF);
        model_write(24'hFE0006, 8'hFF);
        model_write(24'hFE0000, 8'h00);
        model_write(24'hFE0002, 8'h04);
        access("R4 large top", 24'h3FFFFE, 1'b0, 1'b0);
        check("R4 large explicit", {phys_addr, 1'b0}, 24'h7FFFFE);
        access("R5 large above", 24'h400000, 1'b0, 1'b0);
        access("R5 window", 24'hFE0000, 1'b0, 1'b0);
        check("R5 window err", {23'd0, bus_err}, 24'd1);
    endtask

    task automatic t_ignored_writes();
        cyc_write(24'hFE0004, 8'h00, 1'b0, 1'b0, 1'b0);
        access("R8 user write", 24'h3FF000, 1'b0, 1'b0);
        cyc_write(24'hFE0004, 8'h00, 1'b1, 1'b1, 1'b0);
        access("R9 lower lane", 24'h3FF000, 1'b0, 1'b0);
        cyc_write(24'hFE0004, 8'h00, 1'b1, 1'b0, 1'b1);
        access("R9 read", 24'h3FF000, 1'b0, 1'b0);
        cyc_write(24'hFE000C, 8'h00, 1'b1, 1'b0, 1'b0);
        access("R9 slot beyond", 24'h3FF000, 1'b0, 1'b0);
        check("R9 mask kept", {23'd0, bus_err}, 24'd0);
    endtask

    task automatic t_strobe_idle();
        access("R6 idle", 24'hC00000, 1'b0, 1'b1);
        check("R6 explicit", {23'd0, bus_err}, 24'd0);
    endtask

    task automatic t_reset_clears();
        do_reset();
        access("R1 after reset", 24'h3FF123 & 24'hFFFFFE, 1'b0, 1'b0);
    endtask

    initial begin
        do_reset();
        t_reset_state();
        t_supervisor();
        t_small_region();
        t_large_region();
        t_ignored_writes();
        t_strobe_idle();
        t_reset_clears();
        bus_idle();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule